// File: doc/BRIEF.md
# Decode-Stage Operand Forwarding and Stall Controller

This block sits beside the decode stage of a five-stage in-order pipeline and decides, every cycle, how each source operand of the decoding instruction is obtained. An operand can be taken from the memory stage or from the writeback stage, or it can be the hard-wired zero register. When the value cannot be forwarded, the decoding instruction has to wait. The forwarding decision is captured in a register at the same clock edge as the decode-to-execute pipeline register. The execute stage therefore receives the forwarded value together with the instruction that needs it.

The block also raises a stall request. This happens when the decoding instruction depends on a result in execute, on a result in memory that cannot be forwarded (such as a load), or on a control-status register that some in-flight instruction has yet to write. The block also produces the four bubble (kill) signals that clear the fetch, decode, execute and memory stages on reset, a taken branch, a trap, a stall, a fetch that is not ready, or a memory access that is not ready.

The forwarding selection runs as a four-way source choice per operand, with the sources NONE, ZERO, MEM and WB. One choice is made each cycle: ZERO when the operand address is 0, otherwise MEM on a forwardable memory-stage match, otherwise WB on a valid writeback match, otherwise NONE. The choice is held in a register for exactly one cycle and does not depend on earlier choices.

Top module: `pipe_interlock`

## Requirements
- R1: A source address of 0 yields hit=1 and value=0 at the next rising edge, whatever the stage destinations are.
- R2: A nonzero source equal to mem_rd, while mem_valid=1 and mem_fwd_ok=1, yields hit=1 and value=mem_result at the next edge, even if the writeback stage matches too.
- R3: Without a memory-stage forward, a nonzero source equal to wb_rd with wb_valid=1 yields hit=1 and value=wb_result at the next edge; with no match at all, hit=0 and value=0.
- R4: The hit and value outputs change only at a rising clock edge; with rst=1 at an edge they become 0.
- R5: data_stall=1 when dec_valid=1, ex_valid=1, ex_rd is nonzero, and a used source (rs1 with dec_use_rs1, rs2 with dec_use_rs2) equals ex_rd; a source whose use flag is 0 never causes a stall.
- R6: data_stall=1 when dec_valid=1, mem_valid=1, mem_rd is nonzero, mem_fwd_ok=0, and a used source equals mem_rd; with mem_fwd_ok=1 that match causes no stall.
- R7: data_stall=1 when dec_valid=1, dec_use_csr=1, and any of execute, memory or writeback is valid with its CSR-write flag set.
- R8: kill_fetch = rst OR branch_taken OR (fetch_ready=0 AND data_stall=0).
- R9: kill_decode = rst OR branch_taken OR data_stall; kill_execute = rst OR branch_taken.
- R10: kill_memory = rst OR trap OR (mem_is_ldst=1 AND mem_ready=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also kills all stages |
| dec_valid | input | 1 | Decode stage holds a valid instruction |
| dec_rs1 | input | 5 | First source register address |
| dec_rs2 | input | 5 | Second source register address |
| dec_use_rs1 | input | 1 | Instruction reads the first source |
| dec_use_rs2 | input | 1 | Instruction reads the second source |
| dec_use_csr | input | 1 | Instruction reads a CSR |
| ex_valid | input | 1 | Execute stage valid |
| ex_rd | input | 5 | Execute destination register |
| ex_csr_wr | input | 1 | Execute instruction writes a CSR |
| mem_valid | input | 1 | Memory stage valid |
| mem_rd | input | 5 | Memory destination register |
| mem_fwd_ok | input | 1 | Memory-stage result is available for forwarding |
| mem_csr_wr | input | 1 | Memory instruction writes a CSR |
| mem_result | input | 32 | Memory-stage forwardable result |
| mem_is_ldst | input | 1 | Memory instruction is a load or store |
| mem_ready | input | 1 | Data memory access complete |
| wb_valid | input | 1 | Writeback stage valid |
| wb_rd | input | 5 | Writeback destination register |
| wb_csr_wr | input | 1 | Writeback instruction writes a CSR |
| wb_result | input | 32 | Writeback result value |
| fetch_ready | input | 1 | Fetch has an instruction ready |
| branch_taken | input | 1 | A taken branch or jump redirects fetch |
| trap | input | 1 | A trap is being taken |
| rs1_fwd_hit | output | 1 | Registered: first operand supplied by forwarding |
| rs1_fwd_val | output | 32 | Registered: forwarded first operand value |
| rs2_fwd_hit | output | 1 | Registered: second operand supplied by forwarding |
| rs2_fwd_val | output | 32 | Registered: forwarded second operand value |
| data_stall | output | 1 | Decode must hold because of a dependency |
| kill_fetch | output | 1 | Bubble into fetch |
| kill_decode | output | 1 | Bubble into decode |
| kill_execute | output | 1 | Bubble into execute |
| kill_memory | output | 1 | Bubble into memory |

## Verification
The only held state is the pair of registered forwarding choices. A wrong source choice, such as a writeback value winning over a memory value or a lost zero-register override, appears on the hit and value outputs exactly one edge after the offending inputs, and it is gone again one edge later. The stall and kill outputs carry no state. An error in them is therefore visible in the same cycle as the inputs that cause it, and the directed scenarios sample them before the next edge.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_ZERO = 2'd1,
        SRC_MEM  = 2'd2,
        SRC_WB   = 2'd3
    } fwd_src_e;
endpackage

// File: rtl/hzd_operand_fwd.sv
module hzd_operand_fwd
    import hzd_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int RAW  = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [RAW-1:0]  rs_i,
    input  logic            mem_en_i,
    input  logic [RAW-1:0]  mem_rd_i,
    input  logic [XLEN-1:0] mem_val_i,
    input  logic            wb_en_i,
    input  logic [RAW-1:0]  wb_rd_i,
    input  logic [XLEN-1:0] wb_val_i,
    output logic            hit_q,
    output logic [XLEN-1:0] val_q
);
    fwd_src_e        src;
    logic            hit_d;
    logic [XLEN-1:0] val_d;

    always_comb begin
        if (rs_i == '0)
            src = SRC_ZERO;
        else if (mem_en_i && (rs_i == mem_rd_i))
            src = SRC_MEM;
        else if (wb_en_i && (rs_i == wb_rd_i))
            src = SRC_WB;
        else
            src = SRC_NONE;
    end

    always_comb begin
        unique case (src)
            SRC_ZERO: begin hit_d = 1'b1; val_d = '0;        end
            SRC_MEM:  begin hit_d = 1'b1; val_d = mem_val_i; end
            SRC_WB:   begin hit_d = 1'b1; val_d = wb_val_i;  end
            default:  begin hit_d = 1'b0; val_d = '0;        end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q <= 1'b0;
            val_q <= '0;
        end else begin
            hit_q <= hit_d;
            val_q <= val_d;
        end
    end

    // R1
    zero_src_chk: assert property (@(posedge clk) disable iff (rst)
        (rs_i == '0) |=> (hit_q && (val_q == '0)));
    // R2
    mem_prio_chk: assert property (@(posedge clk) disable iff (rst)
        ((rs_i != '0) && mem_en_i && (rs_i == mem_rd_i))
            |=> (hit_q && (val_q == $past(mem_val_i))));
    // R4
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (!hit_q && (val_q == '0)));
endmodule

// File: rtl/hzd_stall_detect.sv
module hzd_stall_detect #(
    parameter int RAW = 5
) (
    input  logic           dec_valid,
    input  logic [RAW-1:0] dec_rs1,
    input  logic [RAW-1:0] dec_rs2,
    input  logic           dec_use_rs1,
    input  logic           dec_use_rs2,
    input  logic           dec_use_csr,
    input  logic           ex_valid,
    input  logic [RAW-1:0] ex_rd,
    input  logic           ex_csr_wr,
    input  logic           mem_valid,
    input  logic [RAW-1:0] mem_rd,
    input  logic           mem_fwd_ok,
    input  logic           mem_csr_wr,
    input  logic           wb_valid,
    input  logic           wb_csr_wr,
    output logic           data_stall
);
    logic ex_dep, mem_dep, csr_dep;

    always_comb begin
        ex_dep  = ex_valid && (ex_rd != '0) &&
                  ((dec_use_rs1 && (dec_rs1 == ex_rd)) ||
                   (dec_use_rs2 && (dec_rs2 == ex_rd)));
        mem_dep = mem_valid && (mem_rd != '0) && !mem_fwd_ok &&
                  ((dec_use_rs1 && (dec_rs1 == mem_rd)) ||
                   (dec_use_rs2 && (dec_rs2 == mem_rd)));
        csr_dep = dec_use_csr &&
                  ((ex_valid && ex_csr_wr) ||
                   (mem_valid && mem_csr_wr) ||
                   (wb_valid && wb_csr_wr));
        data_stall = dec_valid && (ex_dep || mem_dep || csr_dep);
    end
endmodule

// File: rtl/hzd_bubble_ctrl.sv
module hzd_bubble_ctrl (
    input  logic rst,
    input  logic branch_taken,
    input  logic trap,
    input  logic fetch_ready,
    input  logic data_stall,
    input  logic mem_is_ldst,
    input  logic mem_ready,
    output logic kill_fetch,
    output logic kill_decode,
    output logic kill_execute,
    output logic kill_memory
);
    logic redirect;

    always_comb begin
        redirect     = rst || branch_taken;
        kill_fetch   = redirect || (!fetch_ready && !data_stall);
        kill_decode  = redirect || data_stall;
        kill_execute = redirect;
        kill_memory  = rst || trap || (mem_is_ldst && !mem_ready);
    end
endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock #(
    parameter int XLEN = 32,
    parameter int RAW  = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            dec_valid,
    input  logic [RAW-1:0]  dec_rs1,
    input  logic [RAW-1:0]  dec_rs2,
    input  logic            dec_use_rs1,
    input  logic            dec_use_rs2,
    input  logic            dec_use_csr,
    input  logic            ex_valid,
    input  logic [RAW-1:0]  ex_rd,
    input  logic            ex_csr_wr,
    input  logic            mem_valid,
    input  logic [RAW-1:0]  mem_rd,
    input  logic            mem_fwd_ok,
    input  logic            mem_csr_wr,
    input  logic [XLEN-1:0] mem_result,
    input  logic            mem_is_ldst,
    input  logic            mem_ready,
    input  logic            wb_valid,
    input  logic [RAW-1:0]  wb_rd,
    input  logic            wb_csr_wr,
    input  logic [XLEN-1:0] wb_result,
    input  logic            fetch_ready,
    input  logic            branch_taken,
    input  logic            trap,
    output logic            rs1_fwd_hit,
    output logic [XLEN-1:0] rs1_fwd_val,
    output logic            rs2_fwd_hit,
    output logic [XLEN-1:0] rs2_fwd_val,
    output logic            data_stall,
    output logic            kill_fetch,
    output logic            kill_decode,
    output logic            kill_execute,
    output logic            kill_memory
);
    localparam int NOPS = 2;

    logic [RAW-1:0]  op_rs  [NOPS];
    logic            op_hit [NOPS];
    logic [XLEN-1:0] op_val [NOPS];
    logic            mem_en;

    assign op_rs[0] = dec_rs1;
    assign op_rs[1] = dec_rs2;
    assign mem_en   = mem_valid && mem_fwd_ok;

    for (genvar g = 0; g < NOPS; g++) begin : g_op
        hzd_operand_fwd #(.XLEN(XLEN), .RAW(RAW)) u_fwd (
            .clk       (clk),
            .rst       (rst),
            .rs_i      (op_rs[g]),
            .mem_en_i  (mem_en),
            .mem_rd_i  (mem_rd),
            .mem_val_i (mem_result),
            .wb_en_i   (wb_valid),
            .wb_rd_i   (wb_rd),
            .wb_val_i  (wb_result),
            .hit_q     (op_hit[g]),
            .val_q     (op_val[g])
        );
    end

    assign rs1_fwd_hit = op_hit[0];
    assign rs1_fwd_val = op_val[0];
    assign rs2_fwd_hit = op_hit[1];
    assign rs2_fwd_val = op_val[1];

    hzd_stall_detect #(.RAW(RAW)) u_stall (
        .dec_valid   (dec_valid),
        .dec_rs1     (dec_rs1),
        .dec_rs2     (dec_rs2),
        .dec_use_rs1 (dec_use_rs1),
        .dec_use_rs2 (dec_use_rs2),
        .dec_use_csr (dec_use_csr),
        .ex_valid    (ex_valid),
        .ex_rd       (ex_rd),
        .ex_csr_wr   (ex_csr_wr),
        .mem_valid   (mem_valid),
        .mem_rd      (mem_rd),
        .mem_fwd_ok  (mem_fwd_ok),
        .mem_csr_wr  (mem_csr_wr),
        .wb_valid    (wb_valid),
        .wb_csr_wr   (wb_csr_wr),
        .data_stall  (data_stall)
    );

    hzd_bubble_ctrl u_bubble (
        .rst          (rst),
        .branch_taken (branch_taken),
        .trap         (trap),
        .fetch_ready  (fetch_ready),
        .data_stall   (data_stall),
        .mem_is_ldst  (mem_is_ldst),
        .mem_ready    (mem_ready),
        .kill_fetch   (kill_fetch),
        .kill_decode  (kill_decode),
        .kill_execute (kill_execute),
        .kill_memory  (kill_memory)
    );

    // R5
    ex_dep_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && ex_valid && (ex_rd != '0) && dec_use_rs1 && (dec_rs1 == ex_rd))
            |-> data_stall);
    // R9
    stall_kill_chk: assert property (@(posedge clk) disable iff (rst)
        data_stall |-> kill_decode);
    // R8
    fetch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (data_stall && !branch_taken) |-> !kill_fetch);
    // R9
    exec_dec_chk: assert property (@(posedge clk) disable iff (rst)
        kill_execute |-> kill_decode);
    // R10
    trap_kill_chk: assert property (@(posedge clk) disable iff (rst)
        trap |-> kill_memory);
endmodule

// File: tb/sim_pipe_interlock.sv
`timescale 1ns/1ps
module sim_pipe_interlock;
    logic        clk = 1'b0;
    logic        rst;
    logic        dec_valid, dec_use_rs1, dec_use_rs2, dec_use_csr;
    logic [4:0]  dec_rs1, dec_rs2, ex_rd, mem_rd, wb_rd;
    logic        ex_valid, ex_csr_wr, mem_valid, mem_fwd_ok, mem_csr_wr;
    logic [31:0] mem_result, wb_result;
    logic        mem_is_ldst, mem_ready, wb_valid, wb_csr_wr;
    logic        fetch_ready, branch_taken, trap;
    logic        rs1_fwd_hit, rs2_fwd_hit, data_stall;
    logic [31:0] rs1_fwd_val, rs2_fwd_val;
    logic        kill_fetch, kill_decode, kill_execute, kill_memory;
    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    pipe_interlock u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        rst = 1'b0; dec_valid = 1'b1; dec_use_rs1 = 1'b1; dec_use_rs2 = 1'b1;
        dec_use_csr = 1'b0; dec_rs1 = 5'd1; dec_rs2 = 5'd2;
        ex_valid = 1'b0; ex_rd = 5'd0; ex_csr_wr = 1'b0;
        mem_valid = 1'b0; mem_rd = 5'd0; mem_fwd_ok = 1'b1; mem_csr_wr = 1'b0;
        mem_result = 32'h0; mem_is_ldst = 1'b0; mem_ready = 1'b1;
        wb_valid = 1'b0; wb_rd = 5'd0; wb_csr_wr = 1'b0; wb_result = 32'h0;
        fetch_ready = 1'b1; branch_taken = 1'b0; trap = 1'b0;
    endtask

    task automatic edge_then_sample();
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        @(negedge clk); idle(); rst = 1'b1;
        ex_valid = 1'b1; ex_rd = 5'd1;
        #1;
        chk("R8 reset kill_fetch", kill_fetch, 1);
        chk("R9 reset kill_decode", kill_decode, 1);
        chk("R9 reset kill_execute", kill_execute, 1);
        chk("R10 reset kill_memory", kill_memory, 1);
        edge_then_sample();
        chk("R4 reset hit1", rs1_fwd_hit, 0);
        chk("R4 reset val2", rs2_fwd_val, 0);
    endtask

    task automatic t_zero_reg();
        @(negedge clk); idle(); dec_rs1 = 5'd0;
        mem_valid = 1'b1; mem_rd = 5'd0; mem_result = 32'hDEAD0001;
        wb_valid = 1'b1; wb_rd = 5'd0; wb_result = 32'hBEEF0002;
        #1;
        chk("R4 no change before edge", rs1_fwd_hit, 0);
        edge_then_sample();
        chk("R1 zero hit", rs1_fwd_hit, 1);
        chk("R1 zero val", rs1_fwd_val, 0);
    endtask

    task automatic t_alu_back_to_back();
        @(negedge clk); idle(); ex_valid = 1'b1; ex_rd = 5'd5; dec_rs1 = 5'd5;
        fetch_ready = 1'b0;
        #1;
        chk("R5 ex dependency stall", data_stall, 1);
        chk("R9 stall kills decode", kill_decode, 1);
        chk("R9 no execute kill", kill_execute, 0);
        chk("R8 stall holds fetch", kill_fetch, 0);
        dec_use_rs1 = 1'b0; #1;
        chk("R5 unused rs1 no stall", data_stall, 0);
        chk("R8 fetch not ready kills", kill_fetch, 1);
    endtask

    task automatic t_alu_one_later();
        @(negedge clk); idle(); mem_valid = 1'b1; mem_rd = 5'd5; mem_result = 32'h11112222;
        wb_valid = 1'b1; wb_rd = 5'd5; wb_result = 32'h33334444; dec_rs2 = 5'd5;
        #1;
        chk("R6 forwardable mem no stall", data_stall, 0);
        edge_then_sample();
        chk("R2 mem hit", rs2_fwd_hit, 1);
        chk("R2 mem over wb", rs2_fwd_val, 32'h11112222);
        chk("R3 no match hit", rs1_fwd_hit, 0);
        chk("R3 no match val", rs1_fwd_val, 0);
    endtask

    task automatic t_load_use1();
        @(negedge clk); idle(); mem_valid = 1'b1; mem_rd = 5'd7; mem_fwd_ok = 1'b0;
        mem_result = 32'h55556666; dec_rs2 = 5'd7;
        #1;
        chk("R6 load use stall", data_stall, 1);
        edge_then_sample();
        chk("R3 load not forwarded", rs2_fwd_hit, 0);
    endtask

    task automatic t_load_use2();
        @(negedge clk); idle(); wb_valid = 1'b1; wb_rd = 5'd7; wb_result = 32'h77778888;
        dec_rs1 = 5'd7;
        #1;
        chk("R6 wb no stall", data_stall, 0);
        edge_then_sample();
        chk("R3 wb hit", rs1_fwd_hit, 1);
        chk("R3 wb val", rs1_fwd_val, 32'h77778888);
    endtask

    task automatic t_csr();
        @(negedge clk); idle(); dec_use_csr = 1'b1; wb_valid = 1'b1; wb_csr_wr = 1'b1;
        #1;
        chk("R7 csr wb stall", data_stall, 1);
        wb_valid = 1'b0; #1;
        chk("R7 invalid writer no stall", data_stall, 0);
        mem_valid = 1'b1; mem_csr_wr = 1'b1; #1;
        chk("R7 csr mem stall", data_stall, 1);
    endtask

    task automatic t_branch();
        @(negedge clk); idle(); branch_taken = 1'b1;
        #1;
        chk("R8 branch kill_fetch", kill_fetch, 1);
        chk("R9 branch kill_decode", kill_decode, 1);
        chk("R9 branch kill_execute", kill_execute, 1);
        chk("R10 branch no mem kill", kill_memory, 0);
    endtask

    task automatic t_memory_kill();
        @(negedge clk); idle(); mem_is_ldst = 1'b1; mem_ready = 1'b0;
        #1;
        chk("R10 mem wait kill", kill_memory, 1);
        mem_ready = 1'b1; #1;
        chk("R10 mem ready no kill", kill_memory, 0);
        trap = 1'b1; #1;
        chk("R10 trap kill", kill_memory, 1);
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(); rst = 1'b1;
        t_reset();
        t_zero_reg();
        t_alu_back_to_back();
        t_alu_one_later();
        t_load_use1();
        t_load_use2();
        t_csr();
        t_branch();
        t_memory_kill();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule